// File: doc/BRIEF.md
# Prescaled Match-Compare Timer

A bus-mapped timer for a peripheral subsystem. A 32-bit prescale stage counts enabled clocks up to a programmable limit. Each time it reaches that limit it wraps to zero and advances a 32-bit main counter by one. Up to four compare channels watch the main counter. On a match, each channel can set its interrupt flag, restart the counter from zero, or halt the timer by clearing its enable bit. Software can combine these actions in any way per channel.

Software reaches the block through a simple register port: address, write enable, write data and combinational read data. A write is committed on the rising clock edge where the write enable is high. Through this port software can enable the timer, hold it in reset, load the counter, program the prescale limit and the compare values, choose the match actions, and acknowledge flags. The interrupt output is the OR of all pending flags. One count-mode register is provided, and only its plain timer setting counts.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero and `irqOut` is low.
- R2: The prescale limit (offset 0x00C) makes the counter (offset 0x008) advance once per limit+1 enabled clocks. A limit of 0 advances it on every enabled clock.
- R3: Control register (offset 0x004) bit 0 enables counting. While it is clear, the counter keeps its value.
- R4: While control bit 1 is set, the counter and the prescale stage are held at zero. After the bit clears, counting restarts from a zero prescale phase.
- R5: Match control (offset 0x014) gives channel n bits 3n (flag on match), 3n+1 (restart on match) and 3n+2 (halt on match). Channel n compares against the value at offset 0x018+4n, and a match counts only while the timer is counting. With its flag action enabled, a match sets bit n of the flag register (offset 0x000).
- R6: With restart on match and compare value N, the counter runs 0..N and then returns to 0, a period of N+1 counter steps.
- R7: A halt-on-match clears control bit 0 and keeps the counter at N. If restart is also enabled on that channel, the counter goes to zero instead.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R9: `irqOut` is high exactly while any flag bit is set.
- R10: The count-mode register (offset 0x070, 2 bits) reads back. Only value 0 counts; any other value freezes the counter.
- R11: Software writes to offset 0x008 load the counter directly.
- R12: Reads from unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register byte offset |
| busWe | input | 1 | Write strobe, committed on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| irqOut | output | 1 | OR of all interrupt flags |

## Verification
Read data is combinational. A register written at edge E therefore reads back its new value in the cycle after E. Counting starts with the edge after the enable write commits, so after n further edges the counter holds floor(n/(limit+1)), and the bench samples at the falling edge after exactly those n edges. Flags and the halt action take one edge after the counter reaches the compare value. Their checks wait well past that point, except in the same-cycle set/clear case, where the clear is placed inside the long window in which a large prescale limit keeps the match active.

// File: rtl/mt_pkg.sv
package mt_pkg;
  // Register byte offsets; software decodes these so they are fixed
  localparam int OFS_FLAG   = 'h000;
  localparam int OFS_CTRL   = 'h004;
  localparam int OFS_COUNT  = 'h008;
  localparam int OFS_LIMIT  = 'h00C;
  localparam int OFS_ACTION = 'h014;
  localparam int OFS_MATCH0 = 'h018;
  localparam int OFS_MODE   = 'h070;

  // Strobes from control to the counting datapath
  typedef struct packed {
    logic hold;      // keep both counters at zero
    logic zeroNow;   // halt and restart hit together
    logic load;      // software writes the counter
    logic run;       // counting this cycle
    logic wrapZero;  // next counter step returns to zero
  } mt_strobe_t;
endpackage

// File: rtl/mt_datapath.sv
module mt_datapath #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mt_pkg::mt_strobe_t      strb,
  input  logic [CNT_W-1:0]        loadVal,
  input  logic [CNT_W-1:0]        prLimit,
  input  logic [NUM_CH*CNT_W-1:0] matchFlat,
  output logic [CNT_W-1:0]        tcVal,
  output logic [CNT_W-1:0]        pcVal,
  output logic [NUM_CH-1:0]       matchVec
);
  logic wrapNow;
  assign wrapNow = (pcVal == prLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tcVal <= '0;
      pcVal <= '0;
    end else if (strb.hold || strb.zeroNow) begin
      tcVal <= '0;
      pcVal <= '0;
    end else if (strb.load) begin
      tcVal <= loadVal;
    end else if (strb.run) begin
      if (wrapNow) begin
        pcVal <= '0;
        tcVal <= strb.wrapZero ? '0 : tcVal + 1'b1;
      end else begin
        pcVal <= pcVal + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    assign matchVec[i] = (tcVal == matchFlat[i*CNT_W +: CNT_W]);
  end
endmodule

// File: rtl/mt_ctrl.sv
module mt_ctrl #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWe,
  input  logic [DATA_W-1:0]       busWdata,
  output logic [DATA_W-1:0]       busRdata,
  output logic                    irqOut,
  input  logic [NUM_CH-1:0]       matchVec,
  input  logic [CNT_W-1:0]        tcVal,
  output mt_pkg::mt_strobe_t      strb,
  output logic [CNT_W-1:0]        loadVal,
  output logic [CNT_W-1:0]        prLimit,
  output logic [NUM_CH*CNT_W-1:0] matchFlat,
  output logic                    tcrEn,
  output logic                    tcrHold,
  output logic [1:0]              countMode,
  output logic [3*NUM_CH-1:0]     actionReg,
  output logic [NUM_CH-1:0]       flags,
  output logic                    stopHit
);
  import mt_pkg::*;
  localparam int ACT_W = 3 * NUM_CH;

  logic [CNT_W-1:0] matchReg [NUM_CH];
  logic [NUM_CH-1:0] intEn, rstEn, stopEn, hitVec;
  logic active, rstHit;
  logic wrFlag, wrCtrl, wrCount, wrLimit, wrAction, wrMode;
  logic [NUM_CH-1:0] wrMatch;

  // Address decode
  always_comb begin
    wrFlag   = busWe && (busAddr == ADDR_W'(OFS_FLAG));
    wrCtrl   = busWe && (busAddr == ADDR_W'(OFS_CTRL));
    wrCount  = busWe && (busAddr == ADDR_W'(OFS_COUNT));
    wrLimit  = busWe && (busAddr == ADDR_W'(OFS_LIMIT));
    wrAction = busWe && (busAddr == ADDR_W'(OFS_ACTION));
    wrMode   = busWe && (busAddr == ADDR_W'(OFS_MODE));
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign wrMatch[i] = busWe && (busAddr == ADDR_W'(OFS_MATCH0 + 4 * i));
    assign intEn[i]   = actionReg[3*i];
    assign rstEn[i]   = actionReg[3*i+1];
    assign stopEn[i]  = actionReg[3*i+2];
    assign matchFlat[i*CNT_W +: CNT_W] = matchReg[i];

    always_ff @(posedge clk) begin
      if (!rstN)           matchReg[i] <= '0;
      else if (wrMatch[i]) matchReg[i] <= busWdata[CNT_W-1:0];
    end
  end

  // Match qualification and actions
  assign active  = tcrEn && !tcrHold && (countMode == 2'd0);
  assign hitVec  = matchVec & {NUM_CH{active}};
  assign stopHit = |(hitVec & stopEn);
  assign rstHit  = |(hitVec & rstEn);

  always_comb begin
    strb          = '0;
    strb.hold     = tcrHold;
    strb.zeroNow  = stopHit && rstHit;
    strb.load     = wrCount;
    strb.run      = active && !stopHit;
    strb.wrapZero = rstHit;
  end
  assign loadVal = busWdata[CNT_W-1:0];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tcrEn     <= 1'b0;
      tcrHold   <= 1'b0;
      prLimit   <= '0;
      actionReg <= '0;
      countMode <= '0;
    end else begin
      if (wrCtrl) begin
        tcrEn   <= busWdata[0] && !stopHit;
        tcrHold <= busWdata[1];
      end else if (stopHit) begin
        tcrEn   <= 1'b0;
      end
      if (wrLimit)  prLimit   <= busWdata[CNT_W-1:0];
      if (wrAction) actionReg <= busWdata[ACT_W-1:0];
      if (wrMode)   countMode <= busWdata[1:0];
    end
  end

  // Interrupt flags: a new match wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~({NUM_CH{wrFlag}} & busWdata[NUM_CH-1:0]))
                        | (hitVec & intEn);
  end
  assign irqOut = |flags;

  // Read mux, zero for unmapped offsets
  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFS_FLAG))   busRdata[NUM_CH-1:0] = flags;
    if (busAddr == ADDR_W'(OFS_CTRL))   busRdata[1:0]        = {tcrHold, tcrEn};
    if (busAddr == ADDR_W'(OFS_COUNT))  busRdata[CNT_W-1:0]  = tcVal;
    if (busAddr == ADDR_W'(OFS_LIMIT))  busRdata[CNT_W-1:0]  = prLimit;
    if (busAddr == ADDR_W'(OFS_ACTION)) busRdata[ACT_W-1:0]  = actionReg;
    if (busAddr == ADDR_W'(OFS_MODE))   busRdata[1:0]        = countMode;
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(OFS_MATCH0 + 4 * i)) busRdata[CNT_W-1:0] = matchReg[i];
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  mt_pkg::mt_strobe_t      strb;
  logic [CNT_W-1:0]        loadVal, prLimit, tcVal, pcVal;
  logic [NUM_CH*CNT_W-1:0] matchFlat;
  logic [NUM_CH-1:0]       matchVec, flags;
  logic                    tcrEn, tcrHold, stopHit;
  logic [1:0]              countMode;
  logic [3*NUM_CH-1:0]     actionReg;

  mt_ctrl #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .matchVec(matchVec), .tcVal(tcVal),
    .strb(strb), .loadVal(loadVal), .prLimit(prLimit), .matchFlat(matchFlat),
    .tcrEn(tcrEn), .tcrHold(tcrHold), .countMode(countMode), .actionReg(actionReg),
    .flags(flags), .stopHit(stopHit)
  );

  mt_datapath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal), .prLimit(prLimit),
    .matchFlat(matchFlat), .tcVal(tcVal), .pcVal(pcVal), .matchVec(matchVec)
  );
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic                tcrEn,
  input logic                tcrHold,
  input logic [1:0]          countMode,
  input logic [3*NUM_CH-1:0] actionReg,
  input logic [NUM_CH-1:0]   matchVec,
  input logic [NUM_CH-1:0]   flags,
  input logic                irqOut,
  input logic [CNT_W-1:0]    tcVal,
  input logic [CNT_W-1:0]    pcVal,
  input logic                stopHit
);
  logic [NUM_CH-1:0] hitInt;
  logic countWrite;
  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      hitInt[i] = tcrEn && !tcrHold && (countMode == 2'd0) && matchVec[i] && actionReg[3*i];
    countWrite = busWe && (busAddr == ADDR_W'(mt_pkg::OFS_COUNT));
  end

  AST_HOLD_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    tcrHold |=> (tcVal == '0 && pcVal == '0)); // R4

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!tcrEn && !tcrHold && !countWrite) |=> $stable(tcVal)); // R3

  AST_HALT_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    stopHit |=> !tcrEn); // R7

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (hitInt != '0) |=> ((flags & $past(hitInt)) == $past(hitInt))); // R5

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (flags == '0 && hitInt == '0) |=> !irqOut); // R9

  AST_MODE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (countMode != 2'd0 && !tcrHold && !countWrite) |=> $stable(tcVal)); // R10
endmodule

bind match_timer mt_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .tcrEn(tcrEn),
  .tcrHold(tcrHold), .countMode(countMode), .actionReg(actionReg), .matchVec(matchVec),
  .flags(flags), .irqOut(irqOut), .tcVal(tcVal), .pcVal(pcVal), .stopHit(stopHit)
);

// File: tb/match_timer_tb.sv
module match_timer_tb;
  localparam int HALF = 2;  // 250 MHz
  localparam logic [11:0] A_FLAG = 12'h000, A_CTRL = 12'h004, A_CNT = 12'h008,
                          A_LIM = 12'h00C, A_ACT = 12'h014, A_M0 = 12'h018,
                          A_M1 = 12'h01C, A_M2 = 12'h020, A_M3 = 12'h024, A_MODE = 12'h070;

  logic clk = 1'b0, rstN = 1'b0, busWe = 1'b0, irqOut;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  int checks = 0, failures = 0;
  bit done = 0;

  always #HALF clk = ~clk;

  match_timer u_dut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
                     .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitEdges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readCheck(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  // hold, program limit/actions, clear flags, then release with enable
  task automatic startRun(logic [31:0] lim, logic [31:0] act);
    wr(A_CTRL, 32'h2);
    wr(A_LIM, lim);
    wr(A_ACT, act);
    wr(A_FLAG, 32'hF);
    wr(A_CTRL, 32'h1);
  endtask

  task automatic testReset();
    readCheck("R1 flags", A_FLAG, 0);
    readCheck("R1 ctrl", A_CTRL, 0);
    readCheck("R1 count", A_CNT, 0);
    readCheck("R1 limit", A_LIM, 0);
    readCheck("R1 action", A_ACT, 0);
    readCheck("R1 match0", A_M0, 0);
    readCheck("R1 mode", A_MODE, 0);
    check("R1 irq", irqOut, 0);
  endtask

  task automatic testPrescale();
    logic [31:0] a, b;
    startRun(32'd3, 0);
    waitEdges(40);
    readCheck("R2 limit3", A_CNT, 10);
    startRun(32'd0, 0);
    waitEdges(17);
    readCheck("R2 limit0", A_CNT, 17);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, a);
    waitEdges(10);
    rd(A_CNT, b);
    check("R3 disabled holds", b, a);
  endtask

  task automatic testHold();
    startRun(32'd0, 0);
    waitEdges(8);
    wr(A_CTRL, 32'h3);
    waitEdges(5);
    readCheck("R4 held zero", A_CNT, 0);
    wr(A_CTRL, 32'h1);
    waitEdges(6);
    readCheck("R4 after release", A_CNT, 6);
  endtask

  task automatic testFlag();
    wr(A_M0, 32'd5);
    startRun(32'd0, 32'h1);
    waitEdges(10);
    readCheck("R5 no restart", A_CNT, 10);
    readCheck("R5 flag0", A_FLAG, 32'h1);
    check("R9 irq high", irqOut, 1);
    wr(A_FLAG, 32'h0);
    readCheck("R8 write0 keeps", A_FLAG, 32'h1);
    wr(A_FLAG, 32'h1);
    readCheck("R8 write1 clears", A_FLAG, 32'h0);
    check("R9 irq low", irqOut, 0);
  endtask

  task automatic testRestart();
    wr(A_M1, 32'd4);
    startRun(32'd0, 32'h10);
    waitEdges(23);
    readCheck("R6 period5", A_CNT, 3);
    readCheck("R6 no flag", A_FLAG, 0);
  endtask

  task automatic testHalt();
    wr(A_M2, 32'd7);
    startRun(32'd0, 32'h100);
    waitEdges(20);
    readCheck("R7 halt count", A_CNT, 7);
    readCheck("R7 halt ctrl", A_CTRL, 0);
    wr(A_M3, 32'd3);
    startRun(32'd0, 32'hE00);
    waitEdges(20);
    readCheck("R7 halt+restart count", A_CNT, 0);
    readCheck("R7 halt+restart ctrl", A_CTRL, 0);
    readCheck("R5 flag3", A_FLAG, 32'h8);
  endtask

  task automatic testSetWins();
    wr(A_M0, 32'd2);
    startRun(32'd100, 32'h1);
    waitEdges(250);
    wr(A_FLAG, 32'h1);
    readCheck("R8 match beats clear", A_FLAG, 32'h1);
    check("R9 irq stays", irqOut, 1);
  endtask

  task automatic testMode();
    wr(A_MODE, 32'h1);
    startRun(32'd0, 0);
    waitEdges(10);
    readCheck("R10 mode readback", A_MODE, 32'h1);
    readCheck("R10 frozen", A_CNT, 0);
    wr(A_MODE, 32'h0);
    waitEdges(5);
    readCheck("R10 mode0 counts", A_CNT, 5);
  endtask

  task automatic testLoad();
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'h1234);
    readCheck("R11 load", A_CNT, 32'h1234);
    wr(A_CTRL, 32'h1);
    waitEdges(3);
    readCheck("R11 counts on", A_CNT, 32'h1237);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic testUnmapped();
    wr(12'h030, 32'hDEAD);
    readCheck("R12 unmapped write", 12'h030, 0);
    readCheck("R12 gap read", 12'h010, 0);
    readCheck("R12 limit intact", A_LIM, 0);
    readCheck("R12 match1 intact", A_M1, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPrescale();
    testHold();
    testFlag();
    testRestart();
    testHalt();
    testSetWins();
    testMode();
    testLoad();
    testUnmapped();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule